// File: doc/BRIEF.md
# Prescaled Periodic Timer with Buffered Reload

This block is an up-counting periodic timer for interval generation, for example pacing samples out to a converter at a fixed rate. A prescaler divides the clock by a programmable amount. Each prescaler tick advances a main counter, which wraps to zero after it reaches the active reload value. Every wrap, and every update forced by software, raises an update event. The update event drives a one-cycle pulse and sets a sticky interrupt flag.

Software reaches the block through a simple write port. The reload value can be written straight into the active register, or it can be staged in a buffer that moves across only on an update event. The prescaler value is always staged. After reset the active reload is zero, so the timer stands still. If staging is turned on before the first reload write, that write never takes effect until software forces an update.

Top module: `tmr_top`

## Requirements
- R1: After reset, `count` is 0, `upd_pulse` is 0 and `irq_flag` is 0. The active reload, the active prescale and the staging mode (off) are all 0.
- R2: With prescale P and reload A (A > 0) active, update events recur every (P+1)*(A+1) clock cycles. Within each period `count` steps 0, 1, ..., A.
- R3: While the active reload is 0, neither the counter nor the prescaler advances and no overflow update occurs, even with `count_en` high.
- R4: With staging on (address 0, bit 0 = 1), a reload write (address 2) changes only the buffer. The active reload takes the buffer value at the next update event.
- R5: With staging off (address 0, bit 0 = 0), a reload write (address 2) becomes the active reload on the clock edge that accepts it.
- R6: A prescale write (address 1) is staged. It becomes active only at the next update event.
- R7: Writing address 3 with bit 0 = 1 forces an update event. The event copies the staged values, and the counter and prescaler counter restart from 0, so `count` reads 0 after that edge.
- R8: `upd_pulse` is high for exactly the one cycle that follows each update event.
- R9: `irq_flag` is set by every update event, both overflow and forced, and stays set until cleared.
- R10: Writing address 4 with bit 0 = 0 clears `irq_flag`. Writing it with bit 0 = 1 leaves the flag as it is. An update in the same cycle as a clear wins.
- R11: While `count_en` is low and no update is forced, `count` holds its value and no overflow update occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 control, 1 prescale, 2 reload, 3 event, 4 status |
| wr_data | input | DATA_W | Write data |
| count_en | input | 1 | Lets the prescaler and counter advance |
| upd_pulse | output | 1 | One-cycle registered update pulse |
| irq_flag | output | 1 | Sticky update flag |
| count | output | CNT_W | Current main counter value |

## Verification
The bench uses the default 16-bit widths for data, counter and prescaler. Because the programmed values are kept small, whole periods finish in a few cycles, and a prescale of 17 with a reload of 99 shows the full 1800-cycle ratio. At these widths the bench can reach the zero-reload stall, a staged reload that lands one period late, and a direct reload that lands at once. It can also reach a staged prescale, a forced restart in the middle of a count, and flag writes of both polarities.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_PSC    = 3'd1;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd2;
  localparam logic [ADDR_W-1:0] A_EVENT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;

  localparam int BIT_STAGE = 0;
  localparam int BIT_FORCE = 0;
  localparam int BIT_FLAG  = 0;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ue,
  output logic              stage_en,
  output logic [PSC_W-1:0]  psc_act,
  output logic [CNT_W-1:0]  rld_act,
  output logic              force_upd,
  output logic              flag_clr
);
  generate
    if (CNT_W > DATA_W || PSC_W > DATA_W) begin : g_bad_width
      $error("counter or prescaler wider than data port");
    end
  endgenerate

  logic             wr_ctrl, wr_psc, wr_rld;
  logic [PSC_W-1:0] psc_buf;
  logic [CNT_W-1:0] rld_buf;
  logic             wr_data_unused;

  assign wr_data_unused = ^wr_data;

  assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
  assign wr_psc    = wr_en && (wr_addr == A_PSC);
  assign wr_rld    = wr_en && (wr_addr == A_RELOAD);
  assign force_upd = wr_en && (wr_addr == A_EVENT) && wr_data[BIT_FORCE];
  assign flag_clr  = wr_en && (wr_addr == A_STATUS) && !wr_data[BIT_FLAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_en <= 1'b0;
      psc_buf  <= '0;
      psc_act  <= '0;
      rld_buf  <= '0;
      rld_act  <= '0;
    end else begin
      if (wr_ctrl) stage_en <= wr_data[BIT_STAGE];
      if (wr_psc)  psc_buf  <= wr_data[PSC_W-1:0];
      if (wr_rld)  rld_buf  <= wr_data[CNT_W-1:0];
      if (ue)      psc_act  <= psc_buf;
      if (wr_rld && !stage_en)   rld_act <= wr_data[CNT_W-1:0];
      else if (ue && stage_en)   rld_act <= rld_buf;
    end
  end

  // R4: a staged reload never moves without an update
  assert_reload_held_R4: assert property (@(posedge clk) disable iff (rst)
    (stage_en && !ue) |=> $stable(rld_act));

  // R6: the prescale moves only on update events
  assert_psc_staged_R6: assert property (@(posedge clk) disable iff (rst)
    !ue |=> $stable(psc_act));
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] psc_act,
  output logic             tick
);
  logic [PSC_W-1:0] pcnt;

  assign tick = run && (pcnt >= psc_act);

  always_ff @(posedge clk) begin
    if (rst)          pcnt <= '0;
    else if (restart) pcnt <= '0;
    else if (run)     pcnt <= tick ? '0 : pcnt + PSC_W'(1);
  end

  // R6: the divider never runs past the active prescale
  assert_pcnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    pcnt <= psc_act);

  // R7: a forced update restarts the divider
  assert_pcnt_restart_R7: assert property (@(posedge clk) disable iff (rst)
    restart |=> pcnt == '0);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] rld_act,
  output logic             ovf,
  output logic [CNT_W-1:0] cnt
);
  assign ovf = tick && (cnt >= rld_act);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= ovf ? '0 : cnt + CNT_W'(1);
  end

  // R3: a zero reload freezes the counter
  assert_zero_stall_R3: assert property (@(posedge clk) disable iff (rst)
    (rld_act == '0 && !restart) |=> $stable(cnt));

  // R7: forced update restarts the count
  assert_cnt_restart_R7: assert property (@(posedge clk) disable iff (rst)
    restart |=> cnt == '0);
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              count_en,
  output logic              upd_pulse,
  output logic              irq_flag,
  output logic [CNT_W-1:0]  count
);
  logic             stage_en, force_upd, flag_clr;
  logic [PSC_W-1:0] psc_act;
  logic [CNT_W-1:0] rld_act;
  logic             run, tick, ovf, ue;

  assign run = count_en && (rld_act != '0);
  assign ue  = ovf || force_upd;

  tmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ue(ue), .stage_en(stage_en), .psc_act(psc_act), .rld_act(rld_act),
    .force_upd(force_upd), .flag_clr(flag_clr)
  );

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .run(run), .restart(force_upd),
    .psc_act(psc_act), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .restart(force_upd),
    .rld_act(rld_act), .ovf(ovf), .cnt(count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_pulse <= 1'b0;
      irq_flag  <= 1'b0;
    end else begin
      upd_pulse <= ue;
      if (ue)            irq_flag <= 1'b1;
      else if (flag_clr) irq_flag <= 1'b0;
    end
  end

  // R8: each event yields a pulse on the next cycle
  assert_pulse_follows_R8: assert property (@(posedge clk) disable iff (rst)
    ue |=> upd_pulse);

  // R9: every event leaves the flag set
  assert_flag_set_R9: assert property (@(posedge clk) disable iff (rst)
    ue |=> irq_flag);

  // R10: writing one to the flag bit keeps it
  assert_flag_keep_R10: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && wr_en && wr_addr == A_STATUS && wr_data[BIT_FLAG]) |=> irq_flag);

  // R11: counting stops with the enable low
  assert_enable_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!count_en && !force_upd) |=> ($stable(count) && !upd_pulse));

  // R1: stage mode is off coming out of reset
  assert_reset_mode_R1: assert property (@(posedge clk)
    rst |=> (!stage_en && count == '0 && !irq_flag));
endmodule

// File: tb/tmr_top_tb.sv
module tmr_top_tb;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int LIM = 5000;

  // each entry: {prescale, reload, expected period}
  localparam logic [47:0] VEC [0:5] = '{
    {16'd0,  16'd1,  16'd2},
    {16'd1,  16'd3,  16'd8},
    {16'd3,  16'd4,  16'd20},
    {16'd2,  16'd2,  16'd9},
    {16'd0,  16'd6,  16'd7},
    {16'd17, 16'd99, 16'd1800}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          count_en = 1'b0;
  logic          upd_pulse, irq_flag;
  logic [CW-1:0] count;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_top u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count_en(count_en), .upd_pulse(upd_pulse), .irq_flag(irq_flag), .count(count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d, want %0d", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!upd_pulse && n < LIM);
  endtask

  task automatic period_with_write(input logic [2:0] a, input logic [DW-1:0] d,
                                   output int n);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    n = 0;
    do begin
      @(negedge clk);
      wr_en = 1'b0;
      n++;
    end while (!upd_pulse && n < LIM);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    int seen;
    int held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 pulse", int'(upd_pulse), 0);
    chk("R1 flag", int'(irq_flag), 0);

    // R3 zero reload stalls even when enabled
    count_en = 1'b1;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (upd_pulse) seen++;
    end
    chk("R3 count stalled", int'(count), 0);
    chk("R3 no pulses", seen, 0);

    // R4 staged reload written while stalled never lands
    reg_write(3'd0, 16'd1);
    reg_write(3'd2, 16'd4);
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (upd_pulse) seen++;
    end
    chk("R4 still stalled", int'(count), 0);
    chk("R4 no pulses", seen, 0);

    // R7 forced update moves the buffer across
    reg_write(3'd3, 16'd1);
    chk("R7 forced pulse", int'(upd_pulse), 1);
    chk("R7 count restart", int'(count), 0);
    chk("R9 forced sets flag", int'(irq_flag), 1);
    @(negedge clk);
    chk("R8 pulse one cycle", int'(upd_pulse), 0);
    wait_pulse(n);
    chk("R2 period reload 4", n + 1, 5);

    // R4 staged reload written mid-run waits one period
    period_with_write(3'd2, 16'd9, n);
    chk("R4 old period kept", n, 5);
    wait_pulse(n);
    chk("R4 new period", n, 10);

    // R5 direct reload
    reg_write(3'd0, 16'd0);
    wait_pulse(n);
    period_with_write(3'd2, 16'd2, n);
    chk("R5 immediate reload", n, 3);

    // R6 staged prescale
    period_with_write(3'd1, 16'd2, n);
    chk("R6 old prescale kept", n, 3);
    wait_pulse(n);
    chk("R6 new prescale", n, 9);

    // R2 table of prescale / reload pairs
    for (int k = 0; k < 6; k++) begin
      logic [15:0] p, r, e;
      {p, r, e} = VEC[k];
      reg_write(3'd1, p);
      reg_write(3'd2, r);
      reg_write(3'd3, 16'd1);
      chk("R8 pulse after force", int'(upd_pulse), 1);
      chk("R2 table self", int'(e), (int'(p) + 1) * (int'(r) + 1));
      wait_pulse(n);
      chk("R2 period", n, int'(e));
    end

    // R7 forced restart in the middle of a count
    repeat (30) @(negedge clk);
    reg_write(3'd3, 16'd1);
    chk("R7 mid restart count", int'(count), 0);
    chk("R7 mid restart pulse", int'(upd_pulse), 1);

    // R11 enable low freezes count
    repeat (200) @(negedge clk);
    count_en = 1'b0;
    @(negedge clk);
    held = int'(count);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (upd_pulse) seen++;
    end
    chk("R11 count held", int'(count), held);
    chk("R11 no pulses", seen, 0);

    // R10 flag writes
    reg_write(3'd4, 16'd1);
    chk("R10 write one keeps", int'(irq_flag), 1);
    reg_write(3'd4, 16'd0);
    chk("R10 write zero clears", int'(irq_flag), 0);
    repeat (10) @(negedge clk);
    chk("R9 flag stays clear", int'(irq_flag), 0);

    // R9 overflow sets flag and it sticks
    reg_write(3'd1, 16'd0);
    reg_write(3'd2, 16'd3);
    reg_write(3'd3, 16'd1);
    reg_write(3'd4, 16'd0);
    chk("R10 cleared before run", int'(irq_flag), 0);
    count_en = 1'b1;
    wait_pulse(n);
    chk("R9 overflow sets flag", int'(irq_flag), 1);
    repeat (3) @(negedge clk);
    chk("R9 flag sticky", int'(irq_flag), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule